// File: doc/BRIEF.md
# Mode-Configurable Distributed RAM Tile

This block is a small memory tile of 32 words, each 4 bits wide. It has a write port (data, write address, write enable) and a read port (read address, output enable, data output). Two configuration inputs decide how the tile behaves. One selects shared addressing, where the write address also drives the read, or split addressing, where reads and writes use separate addresses in the same cycle. The other selects registered reads or combinational reads.

In combinational-read mode the tile shows a word being written on its output in the cycle the write is presented. Storage is always updated on the clock edge, so the array contains no latches.

A clear request, or the synchronous reset, starts a sweep that writes zero to one word per clock, starting at word 0. A busy flag stays high for the 32 cycles of the sweep. User writes and further clear requests are ignored while the sweep runs.

Top module: `cfg_ram_tile`

## Requirements
- R1: When `we` is high and `busy` is low, `din` is stored at `waddr` on the rising clock edge. Storage is 32 words of 4 bits.
- R2: With `cfg_dual` = 1, the read address is `raddr`, independently of `waddr`, so a read and a write to different words proceed in the same cycle.
- R3: With `cfg_dual` = 0, `raddr` is ignored, and `waddr` addresses both the read and the write.
- R4: With `cfg_sync` = 1, `dout` shows the word at the read address as sampled at the last rising edge. When that edge also wrote the same word, `dout` shows the data from before the write.
- R5: With `cfg_sync` = 0, `dout` follows the current read address combinationally. When a write is accepted in the same cycle to the word being read, `dout` shows `din` (write-through).
- R6: While `oe` is 0, `dout` is all zeros in every mode.
- R7: Reset, or a `cfg_clear` pulse while idle, raises `busy` for exactly 32 cycles. During those cycles words 0 to 31 are cleared, one per cycle. Afterwards every word reads 0.
- R8: `we` has no effect while `busy` is high.
- R9: `cfg_clear` while `busy` is high neither restarts nor lengthens the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clear sweep |
| cfg_sync | input | 1 | 1 = registered read, 0 = combinational read with write-through |
| cfg_dual | input | 1 | 1 = separate read address, 0 = write address shared by both ports |
| cfg_clear | input | 1 | Request to zero the whole array |
| we | input | 1 | Write enable |
| oe | input | 1 | Output enable; 0 forces `dout` to zero |
| din | input | 4 | Write data |
| waddr | input | 5 | Write address (also the read address when shared) |
| raddr | input | 5 | Read address in split mode |
| dout | output | 4 | Read data |
| busy | output | 1 | High while the clear sweep runs |

## Verification
The bench targets a read and a write to the same word in the same cycle in both timing modes. A registered-read design that forwards new data, or a combinational design that fails to forward, shows a wrong nibble in exactly that cycle.

It counts the busy cycles after reset and after a clear request, and it issues clear requests and writes in the middle of a sweep. A sweep that is one cycle short, one that restarts, or one that lets a write through leaves non-zero words or a mistimed `busy`.

Shared-address mode is exercised with a misleading `raddr`, so a design that reads from the wrong address returns visibly different data. Output enable is dropped during active traffic, to show any leak of stored data onto `dout`.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;
  typedef enum logic {PORT_SHARED = 1'b0, PORT_SPLIT = 1'b1} port_mode_e;
  typedef enum logic {READ_COMB = 1'b0, READ_REG = 1'b1} read_mode_e;
endpackage

// File: rtl/ram_clear_seq.sv
module ram_clear_seq #(
  parameter int WORDS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic                       busy,
  output logic [$clog2(WORDS)-1:0]   addr
);
  localparam int AW = $clog2(WORDS);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
        addr <= '0;
      end else begin
        addr <= addr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end

  // R7: the sweep keeps going until the last word
  assert_sweep_continues_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && addr != LAST) |=> busy);
  // R7: the sweep stops right after the last word
  assert_sweep_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && addr == LAST) |=> !busy);
  // R9: the address only advances during a sweep, whatever start does
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && addr != LAST) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/ram_store.sv
module ram_store #(
  parameter int WORDS = 32,
  parameter int WIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_we,
  input  logic [$clog2(WORDS)-1:0] clr_addr,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_now,
  output logic [WIDTH-1:0]         rd_reg
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (clr_we)     mem[clr_addr] <= '0;
    else if (wr_en) mem[wr_addr]  <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_reg <= '0;
    else     rd_reg <= mem[rd_addr];
  end

  assign rd_now = mem[rd_addr];

  // R7: a swept word holds zero after the edge
  assert_clear_word_R7: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> mem[$past(clr_addr)] == '0);
  // R1: an accepted write lands at its address
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr_we) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ram_out_path.sv
module ram_out_path
  import cfg_ram_pkg::*;
#(
  parameter int AW    = 5,
  parameter int WIDTH = 4
) (
  input  read_mode_e       rmode,
  input  logic             oe,
  input  logic             bypass_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] arr_now,
  input  logic [WIDTH-1:0] arr_reg,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    if (!oe)                                   dout = '0;
    else if (rmode == READ_REG)                dout = arr_reg;
    else if (bypass_en && wr_addr == rd_addr)  dout = wr_data;
    else                                       dout = arr_now;
  end
endmodule

// File: rtl/cfg_ram_tile.sv
module cfg_ram_tile
  import cfg_ram_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int WIDTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_sync,
  input  logic                     cfg_dual,
  input  logic                     cfg_clear,
  input  logic                     we,
  input  logic                     oe,
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [WIDTH-1:0]         dout,
  output logic                     busy
);
  localparam int AW = $clog2(WORDS);

  port_mode_e      pmode;
  read_mode_e      rmode;
  logic [AW-1:0]   rd_addr;
  logic [AW-1:0]   clr_addr;
  logic            wr_en;
  logic [WIDTH-1:0] arr_now;
  logic [WIDTH-1:0] arr_reg;

  assign pmode   = port_mode_e'(cfg_dual);
  assign rmode   = read_mode_e'(cfg_sync);
  assign rd_addr = (pmode == PORT_SPLIT) ? raddr : waddr;
  assign wr_en   = we & ~busy;

  ram_clear_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst(rst), .start(cfg_clear), .busy(busy), .addr(clr_addr)
  );

  ram_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .clr_we(busy), .clr_addr(clr_addr),
    .wr_en(wr_en), .wr_addr(waddr), .wr_data(din),
    .rd_addr(rd_addr), .rd_now(arr_now), .rd_reg(arr_reg)
  );

  ram_out_path #(.AW(AW), .WIDTH(WIDTH)) u_out (
    .rmode(rmode), .oe(oe), .bypass_en(wr_en), .wr_addr(waddr),
    .rd_addr(rd_addr), .wr_data(din), .arr_now(arr_now),
    .arr_reg(arr_reg), .dout(dout)
  );

  // R6: a disabled output reads zero
  assert_oe_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !oe |-> dout == '0);
  // R5: shared-address combinational mode always writes through
  assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_sync && !cfg_dual && oe && we && !busy) |-> dout == din);
endmodule

// File: tb/sim_cfg_ram_tile.sv
module sim_cfg_ram_tile;
  localparam int WORDS = 32;
  localparam int WIDTH = 4;
  localparam int AW    = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_sync = 1'b1, cfg_dual = 1'b1, cfg_clear = 1'b0;
  logic we = 1'b0, oe = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [AW-1:0] waddr = '0, raddr = '0;
  logic [WIDTH-1:0] dout;
  logic busy;

  cfg_ram_tile #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .cfg_sync(cfg_sync), .cfg_dual(cfg_dual),
    .cfg_clear(cfg_clear), .we(we), .oe(oe), .din(din), .waddr(waddr),
    .raddr(raddr), .dout(dout), .busy(busy)
  );

  int  model_mem [WORDS];
  int  m_q = 0;
  bit  m_busy = 1'b0;
  int  m_cnt = 0;
  int  compared = 0, mismatched = 0;
  bit  done = 1'b0;
  string phase = "reset";

  initial for (int i = 0; i < WORDS; i++) model_mem[i] = -1;

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin : ref_model
    int ra;
    ra = cfg_dual ? int'(raddr) : int'(waddr);
    if (rst) begin
      m_q = 0; m_busy = 1'b1; m_cnt = 0;
    end else begin
      m_q = model_mem[ra];
      if (m_busy) begin
        model_mem[m_cnt] = 0;
        m_cnt++;
        if (m_cnt == WORDS) begin m_busy = 1'b0; m_cnt = 0; end
      end else begin
        if (we) model_mem[waddr] = int'(din);
        if (cfg_clear) begin m_busy = 1'b1; m_cnt = 0; end
      end
    end
  end

  // compare in the middle of the cycle, before new stimulus
  always @(negedge clk) begin : compare
    int ra, exp;
    string tag;
    if (!rst && !done) begin
      compared++;
      if (busy !== m_busy) begin
        mismatched++;
        $display("FAIL R7 [%s] busy actual=%b expected=%b", phase, busy, m_busy);
      end
      ra = cfg_dual ? int'(raddr) : int'(waddr);
      if (!oe) begin exp = 0; tag = "R6"; end
      else if (cfg_sync) begin exp = m_q; tag = "R4"; end
      else begin
        tag = "R5";
        if (we && !m_busy && int'(waddr) == ra) exp = int'(din);
        else exp = model_mem[ra];
      end
      if (exp >= 0) begin
        compared++;
        if (dout !== WIDTH'(exp)) begin
          mismatched++;
          $display("FAIL %s [%s] dout actual=%h expected=%h", tag, phase, dout, WIDTH'(exp));
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input int a, input int d, input int ra);
    we = 1'b1; waddr = AW'(a); din = WIDTH'(d); raddr = AW'(ra);
    tick();
  endtask

  task automatic rd(input int ra, input int wa);
    we = 1'b0; raddr = AW'(ra); waddr = AW'(wa);
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    tick(4);
    rst = 1'b0;
    phase = "R7 reset sweep";
    tick(34);

    phase = "R1 R2 R4 split registered";
    cfg_sync = 1'b1; cfg_dual = 1'b1;
    for (int i = 0; i < 8; i++) wr(i, i + 3, 31 - i);
    for (int i = 0; i < 8; i++) rd(i, 20);
    wr(5, 15, 5);            // same word: old data expected
    rd(5, 0);
    wr(9, 10, 2);            // simultaneous different addresses
    rd(9, 0);

    phase = "R6 output disabled";
    oe = 1'b0;
    wr(3, 12, 3);
    rd(3, 0); rd(4, 0);
    oe = 1'b1;
    rd(3, 0);

    phase = "R3 shared registered";
    cfg_dual = 1'b0;
    wr(11, 6, 7);
    rd(7, 11); rd(2, 11);
    wr(11, 9, 0);
    rd(30, 11);

    phase = "R5 split comb";
    cfg_sync = 1'b0; cfg_dual = 1'b1;
    wr(12, 13, 12);          // write-through
    wr(13, 1, 12);
    rd(13, 0); rd(12, 0);

    phase = "R3 R5 shared comb";
    cfg_dual = 1'b0;
    wr(14, 2, 5);
    rd(5, 14); rd(5, 12);

    phase = "R7 R8 R9 clear request";
    cfg_clear = 1'b1; we = 1'b0;
    tick();
    cfg_clear = 1'b0;
    wr(1, 7, 1);             // ignored during sweep
    wr(31, 7, 31);
    cfg_clear = 1'b1;        // ignored during sweep
    tick(3);
    cfg_clear = 1'b0;
    tick(30);
    phase = "R7 contents after clear";
    cfg_sync = 1'b1; cfg_dual = 1'b1;
    for (int i = 0; i < WORDS; i++) rd(i, 0);
    cfg_sync = 1'b0;
    for (int i = 0; i < WORDS; i++) rd(i, 0);

    phase = "mixed traffic";
    for (int k = 0; k < 600; k++) begin
      if (k % 25 == 0) begin
        cfg_sync = 1'($urandom_range(0, 1));
        cfg_dual = 1'($urandom_range(0, 1));
      end
      we = 1'($urandom_range(0, 1));
      oe = ($urandom_range(0, 9) != 0);
      cfg_clear = ($urandom_range(0, 79) == 0);
      din = WIDTH'($urandom);
      waddr = AW'($urandom);
      raddr = ($urandom_range(0, 3) == 0) ? waddr : AW'($urandom);
      tick();
    end
    cfg_clear = 1'b0; we = 1'b0;
    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule